// File: doc/BRIEF.md
# Complementary Gate Pair with Deadtime

This block drives the two gates of one inverter leg from a single raw PWM waveform. In complementary mode the high-side gate follows the raw signal and the low-side gate follows its inverse. Whenever one gate turns off, the block holds both gates low for a programmed number of clock cycles before the other gate may turn on. This keeps the upper and lower switches from conducting at the same time.

Each switching direction has its own delay. `dead_rise` is the gap before the high-side gate turns on, and `dead_fall` is the gap before the low-side gate turns on. Each delay is an 11-bit count of clock cycles, so 1 µs at 150 MHz is a count of 150.

Setting `indep_mode` bypasses the deadtime logic. The two raw inputs are then passed to the gates with one register of delay and are not complemented.

The design is centred on one state machine with six states:

- `ST_IDLE`: reset state, both gates low.
- `ST_HI_ON`: high-side gate on.
- `ST_LO_ON`: low-side gate on.
- `ST_GAP_HI`: deadtime before the high-side gate turns on.
- `ST_GAP_LO`: deadtime before the low-side gate turns on.
- `ST_INDEP`: independent pass-through.

The named transitions are:

- **go-hi**: a high raw input in `ST_IDLE`, `ST_LO_ON` or `ST_GAP_LO` leads to `ST_GAP_HI`, loading `dead_rise` into the counter. If `dead_rise` is zero it leads straight to `ST_HI_ON`.
- **go-lo**: the mirror of go-hi, for a low raw input in `ST_IDLE`, `ST_HI_ON` or `ST_GAP_HI`, using `dead_fall`.
- **expire**: `ST_GAP_HI` moves to `ST_HI_ON`, and `ST_GAP_LO` moves to `ST_LO_ON`, when the counter reaches its last cycle.
- **bypass**: any state moves to `ST_INDEP` while `indep_mode` is high.
- **rejoin**: `ST_INDEP` moves to `ST_IDLE` once `indep_mode` is low.

Top module: `dtpair_leg`

## Requirements
- R1: After reset both gates are low, the state is `ST_IDLE` and the deadtime counter is zero.
- R2: In complementary mode (`indep_mode`=0) the two gates are never high in the same cycle, and `pwm_b_in` has no effect on either gate.
- R3: When `pwm_a_in` rises while the low-side gate is on, the low-side gate drops at the next clock edge. Both gates then stay low for exactly `dead_rise` cycles before the high-side gate turns on.
- R4: When `pwm_a_in` falls while the high-side gate is on, the high-side gate drops at the next clock edge. Both gates then stay low for exactly `dead_fall` cycles before the low-side gate turns on.
- R5: A deadtime count of zero swaps the gates at a single clock edge, with no cycle in which both are low.
- R6: If `pwm_a_in` reverses while a deadtime is counting, the counter restarts with the count for the new direction. Both gates stay low until that new count completes.
- R7: While `indep_mode`=1 the high-side gate equals `pwm_a_in` and the low-side gate equals `pwm_b_in`, each sampled at the previous clock edge. Any combination is allowed, including both high.
- R8: When `indep_mode` returns to 0, both gates are low for one cycle in `ST_IDLE`. The block then applies the full deadtime before turning on the gate chosen by `pwm_a_in`, so both gates are low for that count plus one cycle.
- R9: Leaving reset, the first gate turned on in complementary mode also waits its full deadtime count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing counts are in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_a_in | input | 1 | Raw PWM (complementary mode) or high-side source (independent mode) |
| pwm_b_in | input | 1 | Low-side source in independent mode; ignored otherwise |
| dead_rise | input | 11 | Deadtime in cycles before the high-side gate turns on |
| dead_fall | input | 11 | Deadtime in cycles before the low-side gate turns on |
| indep_mode | input | 1 | 1 = independent pass-through, 0 = complementary with deadtime |
| gate_hi | output | 1 | High-side gate drive |
| gate_lo | output | 1 | Low-side gate drive |

## Verification
The assertions assume the two deadtime counts do not change while a deadtime is running. They also assume the mode bit changes only at a clock edge, like every other input. The stimulus follows these assumptions: it reprograms the counts only while a gate has been on and steady. It drives all inputs half a cycle away from the sampling edge, so every change is seen at exactly one edge. Deadtime lengths are measured by counting both-low cycles between gate-on events. The counts are swept over small values, and the largest value is also tested.

// File: rtl/dtpair_pkg.sv
package dtpair_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HI_ON  = 3'd1,
        ST_LO_ON  = 3'd2,
        ST_GAP_HI = 3'd3,
        ST_GAP_LO = 3'd4,
        ST_INDEP  = 3'd5
    } leg_state_t;
endpackage

// File: rtl/dtpair_counter.sv
module dtpair_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - ONE;
    end

    // Last cycle of a running deadtime
    assign expire = (cnt_q == ONE);

    // A load takes effect at the next edge
    assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

    // Without a load, a running count steps down by one
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/dtpair_leg.sv
module dtpair_leg
    import dtpair_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_a_in,
    input  logic             pwm_b_in,
    input  logic [CNT_W-1:0] dead_rise,
    input  logic [CNT_W-1:0] dead_fall,
    input  logic             indep_mode,
    output logic             gate_hi,
    output logic             gate_lo
);
    leg_state_t       state_q, state_d;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic [CNT_W-1:0] cnt;
    logic             expire;
    logic [1:0]       pass_q;

    dtpair_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .cnt_q    (cnt),
        .expire   (expire)
    );

    // State register and independent-mode sample register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pass_q  <= 2'b00;
        end else begin
            state_q <= state_d;
            pass_q  <= {pwm_a_in, pwm_b_in};
        end
    end

    // Next state and counter load
    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        ld_val  = '0;
        if (indep_mode) begin
            state_d = ST_INDEP;           // bypass
            ld      = 1'b1;
        end else begin
            unique case (state_q)
                ST_INDEP: state_d = ST_IDLE;  // rejoin
                ST_IDLE, ST_HI_ON, ST_LO_ON, ST_GAP_HI, ST_GAP_LO: begin
                    if (pwm_a_in && (state_q == ST_IDLE || state_q == ST_LO_ON
                                     || state_q == ST_GAP_LO)) begin
                        // go-hi
                        ld      = 1'b1;
                        ld_val  = dead_rise;
                        state_d = (dead_rise == '0) ? ST_HI_ON : ST_GAP_HI;
                    end else if (!pwm_a_in && (state_q == ST_IDLE || state_q == ST_HI_ON
                                               || state_q == ST_GAP_HI)) begin
                        // go-lo
                        ld      = 1'b1;
                        ld_val  = dead_fall;
                        state_d = (dead_fall == '0) ? ST_LO_ON : ST_GAP_LO;
                    end else if (expire && state_q == ST_GAP_HI) begin
                        state_d = ST_HI_ON;
                    end else if (expire && state_q == ST_GAP_LO) begin
                        state_d = ST_LO_ON;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Output decode
    always_comb begin
        gate_hi = 1'b0;
        gate_lo = 1'b0;
        unique case (state_q)
            ST_HI_ON: gate_hi = 1'b1;
            ST_LO_ON: gate_lo = 1'b1;
            ST_INDEP: begin
                gate_hi = pass_q[1];
                gate_lo = pass_q[0];
            end
            default: ;
        endcase
    end

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !indep_mode |=> !(gate_hi && gate_lo));

    assert_gap_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LO_ON && !indep_mode && pwm_a_in && dead_rise != '0)
        |=> (!gate_hi && !gate_lo));

    assert_gap_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HI_ON && !indep_mode && !pwm_a_in && dead_fall != '0)
        |=> (!gate_hi && !gate_lo));

    assert_zero_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LO_ON && !indep_mode && pwm_a_in && dead_rise == '0)
        |=> (gate_hi && !gate_lo));

    assert_on_idle_cnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HI_ON || state_q == ST_LO_ON) |-> (cnt == '0));

    assert_reverse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP_HI && !indep_mode && !pwm_a_in) |=> !gate_hi);

    assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        indep_mode |=> (gate_hi == $past(pwm_a_in) && gate_lo == $past(pwm_b_in)));

    assert_rejoin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INDEP && !indep_mode) |=> (!gate_hi && !gate_lo));
endmodule

// File: tb/dtpair_leg_tb.sv
module dtpair_leg_tb;
    localparam int W = 11;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_a_in = 1'b0, pwm_b_in = 1'b0, indep_mode = 1'b0;
    logic [W-1:0] dead_rise = '0, dead_fall = '0;
    logic gate_hi, gate_lo;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dtpair_leg #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in),
        .dead_rise(dead_rise), .dead_fall(dead_fall), .indep_mode(indep_mode),
        .gate_hi(gate_hi), .gate_lo(gate_lo));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait (sampling at negedges) until the chosen gate is on, then one more cycle
    task automatic settle(input bit want_hi);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if ((want_hi && gate_hi) || (!want_hi && gate_lo)) break;
        end
        @(negedge clk);
    endtask

    // Count both-low cycles until the target gate turns on
    task automatic measure(input bit to_hi, output int lows, output bit overlap);
        lows = 0; overlap = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (gate_hi && gate_lo) overlap = 1;
            if (to_hi ? gate_hi : gate_lo) break;
            if (gate_hi || gate_lo) overlap = 1;
            lows++;
        end
    endtask

    task automatic sweep(input int r, input int f);
        int lows; bit ov;
        dead_rise = W'(r); dead_fall = W'(f);
        pwm_a_in = 1'b0; settle(1'b0);
        pwm_a_in = 1'b1; pwm_b_in = ~pwm_b_in;
        measure(1'b1, lows, ov);
        chk(lows == r, (r == 0) ? "R5 rise" : "R3 rise", lows, r);
        chk(!ov, "R2 rise", ov, 0);
        @(negedge clk);
        pwm_a_in = 1'b0;
        measure(1'b0, lows, ov);
        chk(lows == f, (f == 0) ? "R5 fall" : "R4 fall", lows, f);
        chk(!ov, "R2 fall", ov, 0);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int lows; bit ov;
        dead_rise = 11'd3; dead_fall = 11'd5;
        repeat (3) @(negedge clk);
        chk(!gate_hi && !gate_lo, "R1 reset", {gate_hi, gate_lo}, 0);
        rst_n = 1'b1;
        // R9: first turn-on out of reset, pwm low -> low gate after dead_fall
        measure(1'b0, lows, ov);
        chk(lows == 5, "R9 first on", lows, 5);

        for (int r = 0; r < 8; r++) sweep(r, 7 - r);
        sweep(2047, 2047);

        // R2: pwm_b_in ignored in complementary mode
        dead_rise = 11'd2; dead_fall = 11'd2;
        pwm_a_in = 1'b1; settle(1'b1);
        for (int i = 0; i < 4; i++) begin
            pwm_b_in = i[0];
            @(negedge clk);
            chk(gate_hi && !gate_lo, "R2 b ignored", {gate_hi, gate_lo}, 2);
        end

        // R6: reverse during rising gap -> restart with dead_fall
        dead_rise = 11'd6; dead_fall = 11'd4;
        pwm_a_in = 1'b0; settle(1'b0);
        pwm_a_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(!gate_hi && !gate_lo, "R6 in gap", {gate_hi, gate_lo}, 0);
        pwm_a_in = 1'b0;
        measure(1'b0, lows, ov);
        chk(lows == 4, "R6 restart", lows, 4);
        chk(!ov, "R6 no hi", ov, 0);

        // R7: independent pass-through, all combinations
        indep_mode = 1'b1;
        for (int v = 0; v < 4; v++) begin
            pwm_a_in = v[1]; pwm_b_in = v[0];
            @(negedge clk);
            chk({gate_hi, gate_lo} == 2'(v), "R7 pass", {gate_hi, gate_lo}, v);
        end

        // R8: rejoin complementary with dead_rise = 3 -> 4 low cycles
        dead_rise = 11'd3;
        pwm_a_in = 1'b1; pwm_b_in = 1'b1;
        @(negedge clk);
        indep_mode = 1'b0;
        measure(1'b1, lows, ov);
        chk(lows == 4, "R8 rejoin", lows, 4);

        // R1: reset mid-operation clears gates
        rst_n = 1'b0;
        @(negedge clk);
        chk(!gate_hi && !gate_lo, "R1 reset again", {gate_hi, gate_lo}, 0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule